// File: doc/BRIEF.md
# Dual-Input Clock Loss Monitor

This block watches two clocks entering a phase-frequency detector: the reference clock and the feedback clock. It runs from its own free-running monitor clock, which is always present. Each watched clock drives a toggle flop in its own domain. That toggle passes through a two-flop synchronizer into the monitor domain, and every change of the synchronized toggle counts as one watched edge.

A controller measures a fixed window of `WINDOW` monitor cycles. At the end of each window it compares the edge count of each clock against `MIN_EDGES`. If either count is short, it sets a sticky loss flag. Only reset or a clear strobe removes that flag.

Detection is off whenever the enable input is low or the external-clock-mode select is high. In that case the window restarts and nothing new is flagged, but a flag already set is kept.

The controller is a three-state machine. The states are:
- `ST_IDLE`: detection is inactive.
- `ST_COUNT`: the window is open and edges are being counted.
- `ST_JUDGE`: the one-cycle verdict at the window boundary.

The transitions are:
- `ST_IDLE -> ST_COUNT`, named `go`: detection becomes active.
- `ST_COUNT -> ST_JUDGE`, named `window_done`: the timer reaches `WINDOW-1`.
- `ST_JUDGE -> ST_COUNT`, named `rearm`: a new window starts.
- Any state `-> ST_IDLE`, named `halt`: detection becomes inactive.

Top module: `clk_loss_monitor`

## Requirements
- R1: While `det_enable` is 0, `loss_flag` never goes from 0 to 1.
- R2: The reference clock and the feedback clock each have their own edge count. Either clock alone running slow is detected while the other runs normally.
- R3: At the end of a window, if either clock's count is below `MIN_EDGES`, `loss_flag` is 1 from the cycle after `ST_JUDGE`. The bench takes a half-period of 0 as a stopped clock.
- R4: Once set, `loss_flag` stays 1 until reset or `clr_flag`, even after both clocks recover.
- R5: While `ext_clk_mode` is 1, the detector is inactive: `loss_flag` is never set and `ref_slow`/`fb_slow` read 0.
- R6: A one-cycle `clr_flag` pulse, given while no new verdict sets the flag, makes `loss_flag` 0 on the next cycle. If a verdict sets the flag in that same cycle, the set wins.
- R7: `ref_slow` (bit 0 of the internal slow vector) and `fb_slow` (bit 1) hold the verdict of the latest window for each clock. They are 0 while detection is inactive.
- R8: Dropping `det_enable` restarts the window and clears `ref_slow`/`fb_slow`, but leaves `loss_flag` unchanged.
- R9: A clock that stops completely is flagged within two windows plus three cycles of stopping.
- R10: During reset, `loss_flag`, `ref_slow` and `fb_slow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock |
| mon_rst_n | input | 1 | Asynchronous active-low reset |
| det_enable | input | 1 | Detection enable |
| ext_clk_mode | input | 1 | External clock mode; forces detection off |
| clr_flag | input | 1 | One-cycle clear strobe for the sticky flag |
| ref_clk | input | 1 | Watched reference clock |
| fb_clk | input | 1 | Watched feedback clock |
| loss_flag | output | 1 | Sticky loss-of-clock flag |
| ref_slow | output | 1 | Latest verdict: reference clock was slow |
| fb_slow | output | 1 | Latest verdict: feedback clock was slow |

## Verification
The verdicts are not due at a fixed cycle after a stimulus, because a change can fall anywhere inside an open window. A change of a watched clock therefore shows up within two windows plus a few cycles: the rest of the current window, one clean window, the verdict cycle, and the output register. The bench waits three full windows before it samples the verdicts, and it samples at the falling edge of the monitor clock. A clear strobe acts one cycle after it is given, so the bench checks it on the next falling edge. The stopped-clock latency is measured by counting monitor cycles against the two-window bound.

// File: rtl/clk_loss_pkg.sv
package clk_loss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_JUDGE = 2'd2
    } mon_state_t;

    localparam int unsigned NUM_WATCHED = 2;
    localparam int unsigned IDX_REF     = 0;
    localparam int unsigned IDX_FB      = 1;

endpackage

// File: rtl/edge_tally.sv
module edge_tally #(
    parameter int unsigned SAT_LIMIT = 16,
    localparam int unsigned CNT_W    = $clog2(SAT_LIMIT + 1)
) (
    input  logic             mon_clk,
    input  logic             mon_rst_n,
    input  logic             watched_clk,
    input  logic             tally_clr,
    output logic [CNT_W-1:0] tally
);

    logic src_tog;
    logic [2:0] sync_q;
    logic seen_edge;

    // toggle in the watched domain, one change per watched rising edge
    always_ff @(posedge watched_clk or negedge mon_rst_n) begin
        if (!mon_rst_n) src_tog <= 1'b0;
        else            src_tog <= ~src_tog;
    end

    // two synchronizing flops plus one history flop
    always_ff @(posedge mon_clk or negedge mon_rst_n) begin
        if (!mon_rst_n) sync_q <= '0;
        else            sync_q <= {sync_q[1:0], src_tog};
    end

    assign seen_edge = sync_q[2] ^ sync_q[1];

    always_ff @(posedge mon_clk or negedge mon_rst_n) begin
        if (!mon_rst_n)
            tally <= '0;
        else if (tally_clr)
            tally <= '0;
        else if (seen_edge && (tally < CNT_W'(SAT_LIMIT)))
            tally <= tally + 1'b1;
    end

endmodule

// File: rtl/window_judge.sv
module window_judge
    import clk_loss_pkg::*;
#(
    parameter int unsigned WINDOW    = 64,
    parameter int unsigned MIN_EDGES = 16,
    localparam int unsigned CNT_W    = $clog2(MIN_EDGES + 1),
    localparam int unsigned TMR_W    = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
    input  logic                   mon_clk,
    input  logic                   mon_rst_n,
    input  logic                   active,
    input  logic                   clr_flag,
    input  logic [CNT_W-1:0]       counts [NUM_WATCHED],
    output logic                   tally_clr,
    output logic                   loss_flag,
    output logic [NUM_WATCHED-1:0] slow
);

    mon_state_t state_q, state_d;
    logic [TMR_W-1:0] timer_q;
    logic [NUM_WATCHED-1:0] short_now;
    logic window_done;

    assign window_done = (timer_q == TMR_W'(WINDOW - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (active) state_d = ST_COUNT;                              // go
            ST_COUNT: if (!active) state_d = ST_IDLE;                              // halt
                      else if (window_done) state_d = ST_JUDGE;                    // window_done
            ST_JUDGE: state_d = active ? ST_COUNT : ST_IDLE;                       // rearm / halt
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge mon_clk or negedge mon_rst_n) begin
        if (!mon_rst_n) state_q <= ST_IDLE;
        else            state_q <= state_d;
    end

    always_ff @(posedge mon_clk or negedge mon_rst_n) begin
        if (!mon_rst_n)                 timer_q <= '0;
        else if (state_q == ST_COUNT)   timer_q <= timer_q + 1'b1;
        else                            timer_q <= '0;
    end

    assign tally_clr = (state_q != ST_COUNT);

    for (genvar g = 0; g < NUM_WATCHED; g++) begin : g_cmp
        assign short_now[g] = (counts[g] < CNT_W'(MIN_EDGES));
    end

    // output process
    always_ff @(posedge mon_clk or negedge mon_rst_n) begin
        if (!mon_rst_n) begin
            loss_flag <= 1'b0;
            slow      <= '0;
        end else begin
            if (!active)
                slow <= '0;
            else if (state_q == ST_JUDGE)
                slow <= short_now;

            if (active && state_q == ST_JUDGE && (|short_now))
                loss_flag <= 1'b1;
            else if (clr_flag)
                loss_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor
    import clk_loss_pkg::*;
#(
    parameter int unsigned WINDOW    = 64,
    parameter int unsigned MIN_EDGES = 16
) (
    input  logic mon_clk,
    input  logic mon_rst_n,
    input  logic det_enable,
    input  logic ext_clk_mode,
    input  logic clr_flag,
    input  logic ref_clk,
    input  logic fb_clk,
    output logic loss_flag,
    output logic ref_slow,
    output logic fb_slow
);

    localparam int unsigned CNT_W = $clog2(MIN_EDGES + 1);

    logic [NUM_WATCHED-1:0] watched;
    logic [CNT_W-1:0] counts [NUM_WATCHED];
    logic [NUM_WATCHED-1:0] slow;
    logic tally_clr;
    logic active;

    assign watched[IDX_REF] = ref_clk;
    assign watched[IDX_FB]  = fb_clk;
    assign active = det_enable && !ext_clk_mode;

    for (genvar g = 0; g < NUM_WATCHED; g++) begin : g_tally
        edge_tally #(.SAT_LIMIT(MIN_EDGES)) u_tally (
            .mon_clk    (mon_clk),
            .mon_rst_n  (mon_rst_n),
            .watched_clk(watched[g]),
            .tally_clr  (tally_clr),
            .tally      (counts[g])
        );
    end

    window_judge #(.WINDOW(WINDOW), .MIN_EDGES(MIN_EDGES)) u_judge (
        .mon_clk  (mon_clk),
        .mon_rst_n(mon_rst_n),
        .active   (active),
        .clr_flag (clr_flag),
        .counts   (counts),
        .tally_clr(tally_clr),
        .loss_flag(loss_flag),
        .slow     (slow)
    );

    assign ref_slow = slow[IDX_REF];
    assign fb_slow  = slow[IDX_FB];

endmodule

// File: rtl/clk_loss_monitor_chk.sv
module clk_loss_monitor_chk (
    input logic mon_clk,
    input logic mon_rst_n,
    input logic det_enable,
    input logic ext_clk_mode,
    input logic clr_flag,
    input logic loss_flag,
    input logic ref_slow,
    input logic fb_slow
);

    a_r4_sticky: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        (loss_flag && !clr_flag) |=> loss_flag);

    a_r1_no_set_when_off: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        (!det_enable || ext_clk_mode) && !loss_flag |=> !loss_flag);

    a_r6_clear: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        (clr_flag && (!det_enable || ext_clk_mode)) |=> !loss_flag);

    a_r5_ext_quiet: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        ext_clk_mode |=> (!ref_slow && !fb_slow));

    a_r8_disable_keeps: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        (!det_enable && loss_flag && !clr_flag) |=> (loss_flag && !ref_slow && !fb_slow));

    a_r3_flag_covers: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        ($rose(ref_slow) || $rose(fb_slow)) |-> loss_flag);

endmodule

bind clk_loss_monitor clk_loss_monitor_chk u_chk (
    .mon_clk     (mon_clk),
    .mon_rst_n   (mon_rst_n),
    .det_enable  (det_enable),
    .ext_clk_mode(ext_clk_mode),
    .clr_flag    (clr_flag),
    .loss_flag   (loss_flag),
    .ref_slow    (ref_slow),
    .fb_slow     (fb_slow)
);

// File: tb/clk_loss_monitor_tb.sv
`timescale 1ns/1ps
module clk_loss_monitor_tb;

    localparam int WIN      = 32;
    localparam int MINE     = 8;
    localparam int MON_NS   = 8;
    localparam int SETTLE   = 3 * (WIN + 1) + 4;
    localparam int LAT_MAX  = 2 * (WIN + 1) + 3;

    logic mon_clk = 1'b0;
    logic mon_rst_n = 1'b0;
    logic det_enable = 1'b1;
    logic ext_clk_mode = 1'b0;
    logic clr_flag = 1'b0;
    logic ref_clk = 1'b0;
    logic fb_clk = 1'b0;
    logic loss_flag, ref_slow, fb_slow;

    int ref_half = 5;
    int fb_half  = 6;
    int checks = 0;
    int failures = 0;

    clk_loss_monitor #(.WINDOW(WIN), .MIN_EDGES(MINE)) u_dut (
        .mon_clk(mon_clk), .mon_rst_n(mon_rst_n), .det_enable(det_enable),
        .ext_clk_mode(ext_clk_mode), .clr_flag(clr_flag), .ref_clk(ref_clk),
        .fb_clk(fb_clk), .loss_flag(loss_flag), .ref_slow(ref_slow), .fb_slow(fb_slow)
    );

    always #(MON_NS/2) mon_clk = ~mon_clk;

    always begin
        if (ref_half == 0) #3;
        else begin #(ref_half); ref_clk = ~ref_clk; end
    end

    always begin
        if (fb_half == 0) #3;
        else begin #(fb_half); fb_clk = ~fb_clk; end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic expect_slow(input int half);
        int edges;
        if (half == 0) return 1'b1;
        edges = (WIN * MON_NS) / (2 * half);
        return edges < MINE;
    endfunction

    task automatic settle();
        repeat (SETTLE) @(negedge mon_clk);
    endtask

    task automatic pulse_clear();
        @(negedge mon_clk) clr_flag = 1'b1;
        @(negedge mon_clk) clr_flag = 1'b0;
    endtask

    initial begin
        #(200000 * MON_NS);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int ref_opts [3] = '{5, 50, 0};
        int fb_opts  [3] = '{6, 60, 0};
        int lat;

        repeat (4) @(negedge mon_clk);
        check("R10 flag in reset", loss_flag, 1'b0);
        check("R10 ref_slow in reset", ref_slow, 1'b0);
        check("R10 fb_slow in reset", fb_slow, 1'b0);
        mon_rst_n = 1'b1;

        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 3; j++) begin
                ref_half = 5; fb_half = 6;
                settle();
                pulse_clear();
                check("R6 clear with good clocks", loss_flag, 1'b0);
                ref_half = ref_opts[i]; fb_half = fb_opts[j];
                settle();
                // R2 R3: each clock judged on its own
                check("R3 flag from sweep", loss_flag,
                      expect_slow(ref_opts[i]) || expect_slow(fb_opts[j]));
                check("R7 ref_slow sweep", ref_slow, expect_slow(ref_opts[i]));
                check("R2 fb_slow sweep", fb_slow, expect_slow(fb_opts[j]));
            end
        end

        ref_half = 5; fb_half = 6;
        settle();
        check("R4 flag sticky after recovery", loss_flag, 1'b1);
        check("R7 ref_slow recovered", ref_slow, 1'b0);
        check("R7 fb_slow recovered", fb_slow, 1'b0);

        ref_half = 0;
        settle();
        det_enable = 1'b0;
        settle();
        check("R8 disable keeps flag", loss_flag, 1'b1);
        check("R8 disable clears ref_slow", ref_slow, 1'b0);
        pulse_clear();
        check("R6 clear while disabled", loss_flag, 1'b0);
        settle();
        check("R1 no set while disabled", loss_flag, 1'b0);

        det_enable = 1'b1; ext_clk_mode = 1'b1; fb_half = 0;
        settle();
        check("R5 no flag in ext mode", loss_flag, 1'b0);
        check("R5 fb_slow in ext mode", fb_slow, 1'b0);

        ext_clk_mode = 1'b0; ref_half = 5; fb_half = 6;
        settle();
        pulse_clear();
        check("R6 clear before latency test", loss_flag, 1'b0);
        ref_half = 0;
        lat = 0;
        while (!loss_flag && lat < 4 * WIN) begin
            @(negedge mon_clk);
            lat++;
        end
        checks++;
        if (lat > LAT_MAX) begin
            failures++;
            $display("FAIL R9 latency actual=%0d expected<=%0d", lat, LAT_MAX);
        end
        check("R9 flag after stop", loss_flag, 1'b1);
        check("R9 ref_slow after stop", ref_slow, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule